// File: doc/BRIEF.md
# Blinded Modular Exponentiation Engine

This block computes `y = x^d mod N` without ever running the exponentiation on the caller's raw operands. When a job is accepted it forms three masked operands from caller-supplied random words. The base becomes `x + r1*N`, the exponent becomes `d + r2*phi`, where `phi` is Euler's totient of `N`, and the working modulus becomes `r3*N`. It reduces the masked base into the working modulus. It then walks the masked exponent from its highest set bit down to bit 0, squaring on every bit and also multiplying by the base on every 1 bit. A last reduction by `N` removes the modulus mask.

All modular products come from one bit-serial multiplier. It consumes one multiplier bit per clock cycle and keeps its partial result below the modulus with conditional subtractions. The caller computes `phi` and draws the random words; a zero `r3` is not a legal request. A job is started by pulsing `start` while `busy` is low. `busy` stays high until the one-cycle `done` pulse, and `y` then holds the result until the next job finishes.

Top module: `blind_modexp`

## Requirements
- R1: A `start` pulse seen while `busy` is low is accepted, and `busy` is high from the next cycle until the job finishes.
- R2: With `r1 = 0`, `r2 = 0` and `r3 = 1`, `y` equals `x^d mod N` for any `x`, `d` and `N >= 1`, including `15^47 mod 26 = 7`.
- R3: When `gcd(x, N) = 1` and `phi` is the totient of `N`, any `r1`, `r2` and any nonzero `r3` give the same `y` as the unmasked run. For example, `x=15`, `d=47`, `N=26`, `phi=12`, `r1=4`, `r2=7`, `r3=5` gives 7.
- R4: When the masked exponent `d + r2*phi` is zero, `y` equals `1 mod N`.
- R5: `done` is high for exactly one cycle, and it rises in the same cycle that `busy` falls.
- R6: A `start` pulse while `busy` is high is ignored: the running job's result and its `busy` interval are unchanged.
- R7: `y` changes only in a cycle in which `done` is high, and otherwise keeps the last result.
- R8: Every intermediate residue held by the engine stays below the modulus it is being reduced by.
- R9: `x` may be equal to or larger than `N`, and the result is still `x^d mod N`.
- R10: With `N = 1` the result is 0.
- R11: Operands at full width (`x`, `d`, `N`, `phi` all 16 bits and `r1 = r2 = r3 = 255`) produce the correct result without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request to begin a job; sampled only while idle |
| x_in | input | 16 | Base |
| d_in | input | 16 | Exponent |
| n_in | input | 16 | Modulus, at least 1 |
| phi_in | input | 16 | Totient of the modulus |
| r1_in | input | 8 | Random multiple of N added to the base |
| r2_in | input | 8 | Random multiple of phi added to the exponent |
| r3_in | input | 8 | Random nonzero factor applied to the modulus |
| busy | output | 1 | High while a job is in progress |
| done | output | 1 | One-cycle pulse when `y` is updated |
| y | output | 16 | Result `x^d mod N` |

## Verification
On every cycle, the assertions check the handshake timing: acceptance, a single `done` pulse aligned with `busy` falling, and `y` changing only on `done`. They also check that the job's masked operands stay frozen while busy and that every residue, in the multiplier and in the exponent walk, stays below its modulus. Whether the arithmetic is right can only be shown by the scenarios. These compare `y` with a right-to-left reference exponentiation computed in the bench. They also show that masked and unmasked runs of the same coprime operands agree, and they cover the zero exponent, `N = 1`, bases at or above `N`, and full-width operands.

// File: rtl/bme_pkg.sv
package bme_pkg;

  // Sequencer phases of the exponentiation engine
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // waiting for a job
    ST_BRED = 3'd1,  // masked base reduced into masked modulus
    ST_SQR  = 3'd2,  // accumulator squared
    ST_MUL  = 3'd3,  // accumulator times base
    ST_FRED = 3'd4   // final reduction by the true modulus
  } bme_state_t;

endpackage

// File: rtl/bme_blind_prep.sv
// Forms the masked operands from the caller's values and random words.
module bme_blind_prep #(
  parameter int NW = 16,
  parameter int RW = 8,
  localparam int WW = NW + RW
) (
  input  logic [NW-1:0] x,
  input  logic [NW-1:0] d,
  input  logic [NW-1:0] n,
  input  logic [NW-1:0] phi,
  input  logic [RW-1:0] r1,
  input  logic [RW-1:0] r2,
  input  logic [RW-1:0] r3,
  output logic [WW-1:0] xb,
  output logic [WW-1:0] db,
  output logic [WW-1:0] nb
);

  // Every sum below is at most 2^RW * (2^NW - 1), so WW bits never overflow
  always_comb begin
    xb = WW'(x) + (WW'(r1) * WW'(n));
    db = WW'(d) + (WW'(r2) * WW'(phi));
    nb = WW'(r3) * WW'(n);
  end

endmodule

// File: rtl/bme_msb_locate.sv
// Finds the position of the highest set bit of a vector.
module bme_msb_locate #(
  parameter int W = 24,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          found
);

  always_comb begin
    idx   = '0;
    found = |vec;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/bme_modmul.sv
// Bit-serial modular multiplier: p = a*b mod m, one bit of a per cycle,
// MSB first. Needs b <= m and m >= 1.
module bme_modmul #(
  parameter int W = 24,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] m,
  output logic         done,
  output logic [W-1:0] p
);

  logic          run_q, run_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  ash_q, ash_d;
  logic [W-1:0]  b_q, b_d;
  logic [W-1:0]  m_q, m_d;
  logic [W-1:0]  acc_q, acc_d;
  logic [W:0]    dbl, dbl_r, sum, sum_r;

  // One Horner step: acc = (2*acc + bit*b) mod m, two conditional subtractions
  always_comb begin
    dbl   = {acc_q, 1'b0};
    dbl_r = (dbl >= {1'b0, m_q}) ? (dbl - {1'b0, m_q}) : dbl;
    sum   = dbl_r + (ash_q[W-1] ? {1'b0, b_q} : '0);
    sum_r = (sum >= {1'b0, m_q}) ? (sum - {1'b0, m_q}) : sum;
  end

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    ash_d  = ash_q;
    b_d    = b_q;
    m_d    = m_q;
    acc_d  = acc_q;
    done_d = 1'b0;
    if (go) begin
      run_d = 1'b1;
      cnt_d = CW'(W);
      ash_d = a;
      b_d   = b;
      m_d   = m;
      acc_d = '0;
    end else if (run_q) begin
      acc_d = sum_r[W-1:0];
      ash_d = ash_q << 1;
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      ash_q  <= '0;
      b_q    <= '0;
      m_q    <= '0;
      acc_q  <= '0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      ash_q  <= ash_d;
      b_q    <= b_d;
      m_q    <= m_d;
      acc_q  <= acc_d;
    end
  end

  assign done = done_q;
  assign p    = acc_q;

  // R8: the partial residue never reaches the modulus while stepping
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (acc_q < m_q));

  // R8: a finished product is a proper residue
  p_result_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (acc_q < m_q));

  // R5: completion follows a running interval and ends it
  p_mm_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(run_q) && !run_q));

  p_mm_count: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q != '0));

endmodule

// File: rtl/blind_modexp.sv
module blind_modexp #(
  parameter int NW = 16,
  parameter int RW = 8,
  localparam int WW = NW + RW,
  localparam int IW = $clog2(WW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] x_in,
  input  logic [NW-1:0] d_in,
  input  logic [NW-1:0] n_in,
  input  logic [NW-1:0] phi_in,
  input  logic [RW-1:0] r1_in,
  input  logic [RW-1:0] r2_in,
  input  logic [RW-1:0] r3_in,
  output logic          busy,
  output logic          done,
  output logic [NW-1:0] y
);
  import bme_pkg::*;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  // Masked operands
  logic [WW-1:0] xb_w, db_w, nb_w;

  bme_blind_prep #(.NW(NW), .RW(RW)) u_prep (
    .x(x_in), .d(d_in), .n(n_in), .phi(phi_in),
    .r1(r1_in), .r2(r2_in), .r3(r3_in),
    .xb(xb_w), .db(db_w), .nb(nb_w)
  );

  bme_state_t    st_q, st_d;
  logic [WW-1:0] xb_q, xb_d, db_q, db_d, nb_q, nb_d;
  logic [NW-1:0] n_q, n_d;
  logic [WW-1:0] base_q, base_d, acc_q, acc_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          go_q, go_d;
  logic          done_q, done_d;
  logic [NW-1:0] y_q, y_d;

  logic [IW-1:0] lead_idx;
  logic          lead_found;

  bme_msb_locate #(.W(WW)) u_lead (
    .vec(db_q), .idx(lead_idx), .found(lead_found)
  );

  // Multiplier operand selection by phase
  logic [WW-1:0] mm_a, mm_b, mm_m, mm_p;
  logic          mm_done;

  always_comb begin
    unique case (st_q)
      ST_SQR: begin
        mm_a = acc_q;  mm_b = acc_q;    mm_m = nb_q;
      end
      ST_MUL: begin
        mm_a = acc_q;  mm_b = base_q;   mm_m = nb_q;
      end
      ST_FRED: begin
        mm_a = acc_q;  mm_b = WW'(1);   mm_m = WW'(n_q);
      end
      default: begin
        mm_a = xb_q;   mm_b = WW'(1);   mm_m = nb_q;
      end
    endcase
  end

  bme_modmul #(.W(WW)) u_mm (
    .clk(clk), .rst_n(rst_core_n), .go(go_q),
    .a(mm_a), .b(mm_b), .m(mm_m),
    .done(mm_done), .p(mm_p)
  );

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    xb_d   = xb_q;
    db_d   = db_q;
    nb_d   = nb_q;
    n_d    = n_q;
    base_d = base_q;
    acc_d  = acc_q;
    idx_d  = idx_q;
    y_d    = y_q;
    go_d   = 1'b0;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          xb_d = xb_w;
          db_d = db_w;
          nb_d = nb_w;
          n_d  = n_in;
          st_d = ST_BRED;
          go_d = 1'b1;
        end
      end
      ST_BRED: begin
        if (mm_done) begin
          base_d = mm_p;
          go_d   = 1'b1;
          if (!lead_found) begin
            acc_d = WW'(1);
            st_d  = ST_FRED;
          end else begin
            acc_d = mm_p;
            if (lead_idx == '0) begin
              st_d = ST_FRED;
            end else begin
              idx_d = lead_idx - IW'(1);
              st_d  = ST_SQR;
            end
          end
        end
      end
      ST_SQR: begin
        if (mm_done) begin
          acc_d = mm_p;
          go_d  = 1'b1;
          if (db_q[idx_q]) begin
            st_d = ST_MUL;
          end else if (idx_q == '0) begin
            st_d = ST_FRED;
          end else begin
            idx_d = idx_q - IW'(1);
            st_d  = ST_SQR;
          end
        end
      end
      ST_MUL: begin
        if (mm_done) begin
          acc_d = mm_p;
          go_d  = 1'b1;
          if (idx_q == '0) begin
            st_d = ST_FRED;
          end else begin
            idx_d = idx_q - IW'(1);
            st_d  = ST_SQR;
          end
        end
      end
      ST_FRED: begin
        if (mm_done) begin
          y_d    = mm_p[NW-1:0];
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q   <= ST_IDLE;
      xb_q   <= '0;
      db_q   <= '0;
      nb_q   <= '0;
      n_q    <= '0;
      base_q <= '0;
      acc_q  <= '0;
      idx_q  <= '0;
      go_q   <= 1'b0;
      done_q <= 1'b0;
      y_q    <= '0;
    end else begin
      st_q   <= st_d;
      xb_q   <= xb_d;
      db_q   <= db_d;
      nb_q   <= nb_d;
      n_q    <= n_d;
      base_q <= base_d;
      acc_q  <= acc_d;
      idx_q  <= idx_d;
      go_q   <= go_d;
      done_q <= done_d;
      y_q    <= y_d;
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign done = done_q;
  assign y    = y_q;

  // R1: an idle request starts a job on the next cycle
  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!busy && start) |=> busy);

  // R5: done coincides with busy falling
  p_done_edge_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    done |-> (!busy && $past(busy)));

  // R5: done lasts one cycle
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    done |=> !done);

  // R7: the result moves only with done
  p_y_hold_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    !$stable(y) |-> done);

  // R6: a running job's masked operands cannot be replaced
  p_ignore_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (busy && !done_d) |=> ($stable(xb_q) && $stable(db_q) && $stable(nb_q) && $stable(n_q)));

  // R8: the exponent walk keeps its accumulator and base as proper residues
  p_acc_range_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (st_q == ST_SQR || st_q == ST_MUL) |-> ((acc_q < nb_q) && (base_q < nb_q)));

  p_idx_range: assert property (@(posedge clk) disable iff (!rst_core_n)
    busy |-> (idx_q < IW'(WW)));

endmodule

// File: tb/sim_blind_modexp.sv
`timescale 1ns/1ps
module sim_blind_modexp;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] x_in = '0, d_in = '0, n_in = 16'd1, phi_in = '0;
  logic [7:0]  r1_in = '0, r2_in = '0, r3_in = 8'd1;
  logic        busy, done;
  logic [15:0] y;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  blind_modexp u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .x_in(x_in), .d_in(d_in), .n_in(n_in), .phi_in(phi_in),
    .r1_in(r1_in), .r2_in(r2_in), .r3_in(r3_in),
    .busy(busy), .done(done), .y(y)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Right-to-left reference exponentiation
  function automatic longint unsigned ref_pow(longint unsigned b, longint unsigned e,
                                              longint unsigned m);
    longint unsigned r = 1 % m;
    b = b % m;
    while (e != 0) begin
      if (e[0]) r = (r * b) % m;
      b = (b * b) % m;
      e = e >> 1;
    end
    return r;
  endfunction

  function automatic int unsigned gcd_u(int unsigned a, int unsigned b);
    while (b != 0) begin
      int unsigned t = a % b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  function automatic int unsigned totient(int unsigned n);
    int unsigned r = n;
    int unsigned m = n;
    for (int unsigned q = 2; q * q <= m; q++) begin
      if (m % q == 0) begin
        while (m % q == 0) m = m / q;
        r = r - r / q;
      end
    end
    if (m > 1) r = r - r / m;
    return r;
  endfunction

  // Issues one job and waits for its completion pulse
  task automatic run_job(input logic [15:0] x, d, n, phi, input logic [7:0] a1, a2, a3,
                         output logic [15:0] res);
    int k = 0;
    @(negedge clk);
    x_in = x; d_in = d; n_in = n; phi_in = phi;
    r1_in = a1; r2_in = a2; r3_in = a3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R1 busy after accepted start", longint'(busy), 1);
    while (done !== 1'b1 && k < 5000) begin
      @(negedge clk);
      k++;
    end
    chk(done === 1'b1, "R1 job completes", longint'(done), 1);
    chk(busy === 1'b0, "R5 busy low with done", longint'(busy), 0);
    res = y;
    @(negedge clk);
    chk(done === 1'b0, "R5 done one cycle", longint'(done), 0);
  endtask

  task automatic t_reset();
    chk(busy === 1'b0, "R1 reset busy", longint'(busy), 0);
    chk(done === 1'b0, "R5 reset done", longint'(done), 0);
    chk(y === 16'd0, "R7 reset y", longint'(y), 0);
  endtask

  task automatic t_worked_example();
    logic [15:0] r;
    run_job(16'd15, 16'd47, 16'd26, 16'd12, 8'd0, 8'd0, 8'd1, r);
    chk(r == 16'd7, "R2 15^47 mod 26 plain", r, 7);
    run_job(16'd15, 16'd47, 16'd26, 16'd12, 8'd4, 8'd7, 8'd5, r);
    chk(r == 16'd7, "R3 15^47 mod 26 masked", r, 7);
  endtask

  task automatic t_plain_random();
    for (int i = 0; i < 8; i++) begin
      logic [15:0] x, d, n, r;
      longint unsigned e;
      x = 16'($urandom_range(0, 65535));
      d = 16'($urandom_range(0, 65535));
      n = 16'($urandom_range(2, 65535));
      e = ref_pow(x, d, n);
      run_job(x, d, n, 16'd0, 8'd0, 8'd0, 8'd1, r);
      chk(r == 16'(e), "R2 plain random", r, longint'(e));
    end
  endtask

  task automatic t_masked_random();
    for (int i = 0; i < 8; i++) begin
      logic [15:0] x, d, n, ph, rp, rm;
      longint unsigned e;
      n  = 16'($urandom_range(3, 65535));
      ph = 16'(totient(n));
      x  = 16'($urandom_range(1, 65535));
      while (gcd_u(x, n) != 1) x = x + 16'd1;
      d  = 16'($urandom_range(1, 65535));
      e  = ref_pow(x, d, n);
      run_job(x, d, n, ph, 8'd0, 8'd0, 8'd1, rp);
      run_job(x, d, n, ph, 8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)),
              8'($urandom_range(1, 255)), rm);
      chk(rm == rp, "R3 masked equals plain", rm, rp);
      chk(rm == 16'(e), "R3 masked vs reference", rm, longint'(e));
    end
  endtask

  task automatic t_zero_exponent();
    logic [15:0] r;
    run_job(16'd9, 16'd0, 16'd11, 16'd10, 8'd3, 8'd0, 8'd2, r);
    chk(r == 16'd1, "R4 zero masked exponent", r, 1);
    run_job(16'd0, 16'd0, 16'd7, 16'd0, 8'd0, 8'd9, 8'd1, r);
    chk(r == 16'd1, "R4 zero exponent zero phi", r, 1);
  endtask

  task automatic t_unit_modulus();
    logic [15:0] r;
    run_job(16'd5, 16'd3, 16'd1, 16'd1, 8'd0, 8'd0, 8'd1, r);
    chk(r == 16'd0, "R10 modulus one", r, 0);
    run_job(16'd5, 16'd0, 16'd1, 16'd1, 8'd2, 8'd0, 8'd3, r);
    chk(r == 16'd0, "R10 modulus one zero exponent", r, 0);
  endtask

  task automatic t_large_base();
    logic [15:0] r;
    longint unsigned e = ref_pow(1000, 13, 37);
    run_job(16'd1000, 16'd13, 16'd37, 16'd36, 8'd0, 8'd0, 8'd1, r);
    chk(r == 16'(e), "R9 base above modulus", r, longint'(e));
    e = ref_pow(37, 5, 37);
    run_job(16'd37, 16'd5, 16'd37, 16'd36, 8'd0, 8'd0, 8'd1, r);
    chk(r == 16'(e), "R9 base equal to modulus", r, longint'(e));
  endtask

  task automatic t_full_width();
    logic [15:0] r;
    longint unsigned e = ref_pow(65535, 65535, 65521);
    run_job(16'hFFFF, 16'hFFFF, 16'd65521, 16'd65520, 8'd255, 8'd255, 8'd255, r);
    chk(r == 16'(e), "R11 full width masked", r, longint'(e));
  endtask

  task automatic t_busy_ignore_and_hold();
    logic [15:0] y0;
    int k = 0;
    longint unsigned e = ref_pow(123, 4567, 9973);
    @(negedge clk);
    x_in = 16'd123; d_in = 16'd4567; n_in = 16'd9973; phi_in = 16'd9972;
    r1_in = 8'd11; r2_in = 8'd13; r3_in = 8'd17;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (100) @(negedge clk);
    x_in = 16'd2; d_in = 16'd3; n_in = 16'd5; phi_in = 16'd4;
    r1_in = 8'd0; r2_in = 8'd0; r3_in = 8'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && done === 1'b0, "R6 busy kept after ignored start", longint'(busy), 1);
    while (done !== 1'b1 && k < 5000) begin
      @(negedge clk);
      k++;
    end
    chk(y == 16'(e), "R6 running job result kept", y, longint'(e));
    y0 = y;
    repeat (30) @(negedge clk);
    chk(y == y0, "R7 result held while idle", y, y0);
    chk(busy === 1'b0, "R6 no job queued by ignored start", longint'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_worked_example();
    t_plain_random();
    t_masked_random();
    t_zero_exponent();
    t_unit_modulus();
    t_large_base();
    t_full_width();
    t_busy_ignore_and_hold();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule